// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out one already-decoded multi-register stack instruction, either a save (push) or a restore (pop), as a series of single-word accesses to a single-ported data memory. It moves one register per cycle. It sits between an eight-entry, 16-bit register file and that memory. On a start strobe it captures the operation, the range anchor (operand A), the register count and the index of the register that acts as stack pointer. In the same cycle it reads the current pointer value through the register-file read port. It then steps through the range, writes the updated pointer back into the selected register and pulses `done`.

The range always begins at anchor + 1, so register 0 is never moved by the range. A pop restores registers in ascending index order. A push saves them in descending order, so that the register at anchor + 1 is saved last. A push writes at the pointer and then decrements it. A pop increments the pointer and then reads. The two therefore undo each other. All stack accesses lie in the lowest 64K-word page, and the pointer wraps modulo 2^16.

Two pop encodings have a fixed meaning, and both use anchor 5 with register 0 as the pointer. With count 2 the block restores the status and program-counter registers, which is a subroutine return. With count 3 it also reads a third word, the saved interrupt-enable flags. That word is presented on `flag_data` together with `flag_stb` for the interrupt controller and is not written to any register.

The controller has five named states. `ST_IDLE` waits for a start. `ST_XFER` moves one register per cycle. `ST_FLAG` reads the flag word of an interrupt return. `ST_WRSP` writes the pointer back and signals done. `ST_FIN0` signals done for an empty transfer.

The transitions are:
- `ST_IDLE` to `ST_XFER` on a start with a non-empty effective range.
- `ST_IDLE` to `ST_FIN0` on a start with an empty range.
- `ST_XFER` to itself until the last register has moved.
- `ST_XFER` to `ST_FLAG` after the last register of an interrupt return.
- `ST_XFER` to `ST_WRSP` after the last register otherwise.
- `ST_FLAG` to `ST_WRSP`.
- `ST_WRSP` to `ST_IDLE`.
- `ST_FIN0` to `ST_IDLE`.

Top module: `stk_xfer_seq`

## Requirements
- R1: After reset and whenever no operation is in progress, `busy`, `done`, `mem_we`, `mem_re`, `rf_wr_en` and `flag_stb` are all 0.
- R2: A push (`op_pop`=0) with effective count n and captured pointer P writes register anchor+n at address P, anchor+n-1 at P-1, and so on down to anchor+1 at P-n+1. The writes use one `mem_we` cycle each, the first in the cycle after the start, and `mem_wdata` carries the register value.
- R3: A pop (`op_pop`=1) with effective count n reads addresses P+1 up to P+n in consecutive cycles starting the cycle after the start. Each word read is written in the same cycle to registers anchor+1 upward, so a pop with the same anchor and count undoes a push.
- R4: In the cycle after the last memory access, the block writes the pointer register (`sp_sel`) with P-n for a push, or with P plus the number of words read for a pop, modulo 2^16. `done` is high for exactly that one cycle.
- R5: The effective count is the requested count limited to 7 minus anchor, so that the range never passes register 7. The one exception is the interrupt-return encoding of R7.
- R6: An effective count of 0 gives `done` (with `busy`) in the cycle after the start, with no memory access and no register write.
- R7: A pop with anchor 5, count 3 and pointer register 0 restores registers 6 and 7 from P+1 and P+2. In the following cycle it reads P+3, presents that word on `flag_data` with `flag_stb`=1 and `rf_wr_en`=0, and then writes P+3 to register 0. The same count with any other pointer register is clamped by R5.
- R8: A pop with anchor 5, count 2 and pointer register 0 restores registers 6 and 7 and never raises `flag_stb`.
- R9: Register 0 is written only by the pointer write-back, never as part of the transferred range.
- R10: A start while `busy` is 1, including the `done` cycle, is ignored, and the fields presented with it have no effect.
- R11: Pointer and address arithmetic wraps within 16 bits, so 0x0000 minus 1 is 0xFFFF and 0xFFFF plus 1 is 0x0000.
- R12: `mem_we` and `mem_re` are never both 1, and `flag_stb` is never high together with `rf_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_pop | input | 1 | 1 = pop (restore), 0 = push (save) |
| base_sel | input | 3 | Range anchor; the range starts at anchor + 1 |
| xfer_cnt | input | 3 | Requested number of registers |
| sp_sel | input | 3 | Index of the register used as stack pointer |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 16 | Register-file read data (same cycle) |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 16 | Register-file write data |
| mem_addr | output | 16 | Data-memory word address (page 0) |
| mem_wdata | output | 16 | Data-memory write data |
| mem_we | output | 1 | Data-memory write enable |
| mem_re | output | 1 | Data-memory read enable |
| mem_rdata | input | 16 | Data-memory read data (same cycle) |
| flag_stb | output | 1 | Interrupt-flag word is valid on `flag_data` |
| flag_data | output | 16 | Restored interrupt-flag word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Completion and a fresh request can coincide: `done` is high in the same cycle that a start arrives. The bench provokes this by holding `start` high from the cycle after acceptance through the `done` cycle, while presenting a different opcode, anchor and count. The per-cycle model then expects an idle cycle after `done` with no further access. In the interrupt-return case, the flag strobe and a register write-back are the two events that must never share a cycle, and the model expects the flag word alone in its own cycle.

// File: rtl/stk_xfer_pkg.sv
package stk_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_XFER = 3'd1,
        ST_FLAG = 3'd2,
        ST_WRSP = 3'd3,
        ST_FIN0 = 3'd4
    } seq_state_e;

endpackage

// File: rtl/stk_xfer_ctrl.sv
module stk_xfer_ctrl
    import stk_xfer_pkg::*;
#(
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 3,
    parameter int RET_BASE = 5,
    parameter int RET_SP   = 0,
    parameter int RETI_CNT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_pop,
    input  logic [IDX_W-1:0] base,
    input  logic [CNT_W-1:0] cnt,
    input  logic [IDX_W-1:0] sp_sel,
    output logic             accept,
    output logic             pop_q,
    output logic [IDX_W-1:0] base_q,
    output logic [IDX_W-1:0] sp_sel_q,
    output logic [CNT_W-1:0] num_q,
    output logic [CNT_W-1:0] step_q,
    output logic             xfer_act,
    output logic             flag_act,
    output logic             wrsp_act,
    output logic             fin_act,
    output logic             busy
);

    localparam int LAST_IDX = (1 << IDX_W) - 1;
    localparam int SUM_W    = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;

    seq_state_e       state, state_nx;
    logic [SUM_W-1:0] room, cnt_w;
    logic [CNT_W-1:0] eff_cnt;
    logic             ret_int, ret_q, last_step;

    // effective range size, limited so the range ends at the top register
    always_comb begin
        room    = SUM_W'(LAST_IDX) - SUM_W'(base);
        cnt_w   = SUM_W'(cnt);
        ret_int = op_pop && (base == IDX_W'(RET_BASE)) &&
                  (cnt == CNT_W'(RETI_CNT)) && (sp_sel == IDX_W'(RET_SP));
        if (ret_int)
            eff_cnt = CNT_W'(RETI_CNT - 1);
        else if (cnt_w > room)
            eff_cnt = CNT_W'(room);
        else
            eff_cnt = cnt;
    end

    assign accept    = (state == ST_IDLE) && start;
    assign last_step = (step_q == (num_q - CNT_W'(1)));

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (eff_cnt == '0)
                        state_nx = ST_FIN0;
                    else
                        state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                if (last_step)
                    state_nx = ret_q ? ST_FLAG : ST_WRSP;
            end
            ST_FLAG: state_nx = ST_WRSP;
            ST_WRSP: state_nx = ST_IDLE;
            ST_FIN0: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // captured operation and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_q    <= 1'b0;
            base_q   <= '0;
            sp_sel_q <= '0;
            num_q    <= '0;
            step_q   <= '0;
            ret_q    <= 1'b0;
        end else if (accept) begin
            pop_q    <= op_pop;
            base_q   <= base;
            sp_sel_q <= sp_sel;
            num_q    <= eff_cnt;
            step_q   <= '0;
            ret_q    <= ret_int;
        end else if (state == ST_XFER) begin
            step_q   <= step_q + CNT_W'(1);
        end
    end

    // state-decoded strobes
    always_comb begin
        xfer_act = 1'b0;
        flag_act = 1'b0;
        wrsp_act = 1'b0;
        fin_act  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_XFER: xfer_act = 1'b1;
            ST_FLAG: flag_act = 1'b1;
            ST_WRSP: wrsp_act = 1'b1;
            ST_FIN0: fin_act  = 1'b1;
            default: ;
        endcase
        busy = (state != ST_IDLE);
    end

    AST_EMPTY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_act |=> !busy); // R6

    AST_FLAG_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        flag_act |-> ($past(xfer_act) && pop_q)); // R7

endmodule

// File: rtl/stk_xfer_idx.sv
module stk_xfer_idx #(
    parameter int IDX_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             pop_q,
    input  logic [IDX_W-1:0] base_q,
    input  logic [CNT_W-1:0] num_q,
    input  logic [CNT_W-1:0] step_q,
    output logic [IDX_W-1:0] reg_idx
);

    logic [IDX_W-1:0] step_i, num_i;

    always_comb begin
        step_i = IDX_W'(step_q);
        num_i  = IDX_W'(num_q);
        if (pop_q)
            reg_idx = base_q + IDX_W'(1) + step_i;   // ascending from anchor+1
        else
            reg_idx = base_q + num_i - step_i;       // descending to anchor+1
    end

endmodule

// File: rtl/stk_xfer_ptr.sv
module stk_xfer_ptr #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step_en,
    input  logic              pop,
    output logic [DATA_W-1:0] addr,
    output logic [DATA_W-1:0] sp_q
);

    // pop pre-increments, push uses the pointer then decrements
    assign addr = pop ? (sp_q + DATA_W'(1)) : sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (load)
            sp_q <= load_val;
        else if (step_en)
            sp_q <= pop ? (sp_q + DATA_W'(1)) : (sp_q - DATA_W'(1));
    end

    AST_LOAD_NOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !step_en); // R10

endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq #(
    parameter int DATA_W   = 16,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 3,
    parameter int RET_BASE = 5,
    parameter int RET_SP   = 0,
    parameter int RETI_CNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_pop,
    input  logic [IDX_W-1:0]  base_sel,
    input  logic [CNT_W-1:0]  xfer_cnt,
    input  logic [IDX_W-1:0]  sp_sel,
    output logic [IDX_W-1:0]  rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_wr_en,
    output logic [IDX_W-1:0]  rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              flag_stb,
    output logic [DATA_W-1:0] flag_data,
    output logic              busy,
    output logic              done
);

    logic              accept, pop_q;
    logic [IDX_W-1:0]  base_q, sp_sel_q, reg_idx;
    logic [CNT_W-1:0]  num_q, step_q;
    logic              xfer_act, flag_act, wrsp_act, fin_act;
    logic [DATA_W-1:0] ptr_addr, sp_q;

    stk_xfer_ctrl #(
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W),
        .RET_BASE (RET_BASE),
        .RET_SP   (RET_SP),
        .RETI_CNT (RETI_CNT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_pop   (op_pop),
        .base     (base_sel),
        .cnt      (xfer_cnt),
        .sp_sel   (sp_sel),
        .accept   (accept),
        .pop_q    (pop_q),
        .base_q   (base_q),
        .sp_sel_q (sp_sel_q),
        .num_q    (num_q),
        .step_q   (step_q),
        .xfer_act (xfer_act),
        .flag_act (flag_act),
        .wrsp_act (wrsp_act),
        .fin_act  (fin_act),
        .busy     (busy)
    );

    stk_xfer_idx #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_idx (
        .pop_q   (pop_q),
        .base_q  (base_q),
        .num_q   (num_q),
        .step_q  (step_q),
        .reg_idx (reg_idx)
    );

    stk_xfer_ptr #(
        .DATA_W (DATA_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (rf_rd_data),
        .step_en  (xfer_act | flag_act),
        .pop      (pop_q),
        .addr     (ptr_addr),
        .sp_q     (sp_q)
    );

    // port-level output decode
    always_comb begin
        rf_rd_idx  = xfer_act ? reg_idx : sp_sel;
        mem_addr   = ptr_addr;
        mem_wdata  = rf_rd_data;
        mem_we     = xfer_act && !pop_q;
        mem_re     = (xfer_act || flag_act) && pop_q;
        rf_wr_en   = (xfer_act && pop_q) || wrsp_act;
        rf_wr_idx  = wrsp_act ? sp_sel_q : reg_idx;
        rf_wr_data = wrsp_act ? sp_q : mem_rdata;
        flag_stb   = flag_act;
        flag_data  = mem_rdata;
        done       = wrsp_act || fin_act;
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R12

    AST_FLAG_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_stb |-> !rf_wr_en); // R7

    AST_NO_R0_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && !done) |-> (rf_wr_idx != '0)); // R9

    AST_PUSH_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == ($past(mem_addr) - DATA_W'(1)))); // R2

    AST_POP_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |-> (mem_addr == ($past(mem_addr) + DATA_W'(1)))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

endmodule

// File: tb/stk_xfer_seq_bench.sv
module stk_xfer_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        busy, done, we, re, rwe, fstb;
        logic [15:0] addr, wdata, rdata, fdata;
        logic [2:0]  ridx;
        logic [7:0]  tg;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_pop = 1'b0;
    logic [2:0]  base_sel = '0, xfer_cnt = '0, sp_sel = '0;
    logic [2:0]  rf_rd_idx, rf_wr_idx;
    logic [15:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata, mem_rdata, flag_data;
    logic        rf_wr_en, mem_we, mem_re, flag_stb, busy, done;

    logic [15:0] rf  [8];
    logic [15:0] mem [256];    // page 0 modelled by the low address byte
    exp_t        q[$];
    int          errors = 0, checks = 0, cyc = 0, idle_tag = 1;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_xfer_seq u_stk_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op_pop(op_pop),
        .base_sel(base_sel), .xfer_cnt(xfer_cnt), .sp_sel(sp_sel),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .flag_stb(flag_stb), .flag_data(flag_data),
        .busy(busy), .done(done)
    );

    // environment: register file and memory answering the design
    assign rf_rd_data = rf[rf_rd_idx];
    assign mem_rdata  = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
        if (mem_we)   mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input int tg, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", tg, what, act, expv);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // per-cycle comparison against the queued reference
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !finished) begin
            if (q.size() > 0) begin
                e = q.pop_front();
            end else begin
                e = '0;
                e.tg = 8'(idle_tag);   // R1 idle outputs (R10 after an ignored start)
            end
            chk({busy, done, mem_we, mem_re, rf_wr_en, flag_stb} ==
                {e.busy, e.done, e.we, e.re, e.rwe, e.fstb}, e.tg, "strobes",
                {10'd0, busy, done, mem_we, mem_re, rf_wr_en, flag_stb},
                {10'd0, e.busy, e.done, e.we, e.re, e.rwe, e.fstb});
            if (e.we) begin
                chk(mem_addr == e.addr, e.tg, "push address", mem_addr, e.addr);
                chk(mem_wdata == e.wdata, e.tg, "push data", mem_wdata, e.wdata);
            end
            if (e.re)
                chk(mem_addr == e.addr, e.tg, "pop address", mem_addr, e.addr);
            if (e.rwe) begin
                chk(rf_wr_idx == e.ridx, e.tg, "reg index", 16'(rf_wr_idx), 16'(e.ridx));
                chk(rf_wr_data == e.rdata, e.tg, "reg data", rf_wr_data, e.rdata);
            end
            if (e.fstb)
                chk(flag_data == e.fdata, e.tg, "flag word", flag_data, e.fdata);
            if (rf_wr_en && !done)   // R9
                chk(rf_wr_idx != 3'd0, 9, "range wrote register 0", 16'(rf_wr_idx), 16'd1);
            chk(!(mem_we && mem_re), 12, "we and re together",   // R12
                {15'd0, mem_we & mem_re}, 16'd0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
        end
    end

    task automatic wait_idle();
        while (q.size() != 0) begin
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
    endtask

    // build the expected cycle sequence from the requirements, then drive
    task automatic run_op(input bit pop, input int base, input int cnt, input int spi,
                          input int tg, input bit hold);
        exp_t        e;
        logic [15:0] sp;
        int          eff;
        bit          reti;
        wait_idle();
        reti = pop && base == 5 && cnt == 3 && spi == 0;
        eff  = reti ? 2 : ((cnt > 7 - base) ? 7 - base : cnt);
        sp   = rf[spi];
        e = '0; e.tg = 8'(tg);
        q.push_back(e);                               // the start cycle itself
        if (eff == 0) begin
            e = '0; e.busy = 1; e.done = 1; e.tg = 8'(tg);
            q.push_back(e);
        end else begin
            for (int s = 0; s < eff; s++) begin
                e = '0; e.busy = 1; e.tg = 8'(tg);
                if (pop) begin
                    e.re = 1; e.rwe = 1;
                    e.addr  = sp + 16'(s + 1);
                    e.ridx  = 3'(base + 1 + s);
                    e.rdata = mem[e.addr[7:0]];
                end else begin
                    e.we = 1;
                    e.addr  = sp - 16'(s);
                    e.wdata = rf[3'(base + eff - s)];
                end
                q.push_back(e);
            end
            if (reti) begin
                e = '0; e.busy = 1; e.re = 1; e.fstb = 1; e.tg = 8'(tg);
                e.addr  = sp + 16'd3;
                e.fdata = mem[e.addr[7:0]];
                q.push_back(e);
            end
            e = '0; e.busy = 1; e.done = 1; e.rwe = 1; e.tg = 8'(tg);
            e.ridx  = 3'(spi);
            e.rdata = pop ? sp + 16'(eff + (reti ? 1 : 0)) : sp - 16'(eff);
            q.push_back(e);
        end
        start = 1'b1; op_pop = pop;
        base_sel = 3'(base); xfer_cnt = 3'(cnt); sp_sel = 3'(spi);
        @(posedge clk); #1;
        if (hold) begin
            // R10: keep requesting with other fields until after the done cycle
            op_pop = ~pop; base_sel = 3'd0; xfer_cnt = 3'd6; sp_sel = 3'd3;
            while (q.size() > 1) begin
                @(posedge clk); #1;
            end
            @(posedge clk); #1;
        end
        start = 1'b0;
    endtask

    logic [15:0] saved [8];

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        rf[0] = 16'h0080;
        for (int i = 1; i < 8; i++) rf[i] = 16'hA000 + 16'(i * 16'h0111);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !done && !mem_we && !mem_re && !rf_wr_en && !flag_stb, 1,
            "reset outputs (R1)", {10'd0, busy, done, mem_we, mem_re, rf_wr_en, flag_stb}, 16'd0);

        for (int i = 0; i < 8; i++) saved[i] = rf[i];
        run_op(1'b0, 0, 3, 0, 2, 1'b0);              // R2 push R3..R1, R4 write-back
        wait_idle();
        rf[1] = 16'h0; rf[2] = 16'h0; rf[3] = 16'h0;
        run_op(1'b1, 0, 3, 0, 3, 1'b0);              // R3 pop restores
        wait_idle();
        for (int i = 1; i < 4; i++)
            chk(rf[i] == saved[i], 3, "restored register", rf[i], saved[i]);
        chk(rf[0] == 16'h0080, 4, "pointer after round trip", rf[0], 16'h0080);

        run_op(1'b0, 4, 3, 5, 2, 1'b0);              // R2 pointer inside the range
        run_op(1'b0, 5, 6, 0, 5, 1'b0);              // R5 clamp to 2
        run_op(1'b0, 7, 4, 0, 5, 1'b0);              // R5 anchor 7 gives empty range
        run_op(1'b1, 2, 0, 0, 6, 1'b0);              // R6 count zero
        run_op(1'b1, 6, 5, 0, 5, 1'b0);              // R5 pop clamp to 1

        wait_idle();
        rf[0] = 16'h0020; mem[8'h21] = 16'h1357; mem[8'h22] = 16'h2468;
        run_op(1'b1, 5, 2, 0, 8, 1'b0);              // R8 subroutine return
        wait_idle();
        rf[0] = 16'h0040;
        mem[8'h41] = 16'h0F0F; mem[8'h42] = 16'h3C3C; mem[8'h43] = 16'h0003;
        run_op(1'b1, 5, 3, 0, 7, 1'b0);              // R7 interrupt return
        wait_idle();
        chk(rf[6] == 16'h0F0F && rf[7] == 16'h3C3C, 7, "status/pc restored", rf[7], 16'h3C3C);
        rf[1] = 16'h0040;
        run_op(1'b1, 5, 3, 1, 5, 1'b0);              // R7 other pointer: clamped, no flag

        wait_idle();
        rf[2] = 16'h0001;
        run_op(1'b0, 3, 4, 2, 11, 1'b0);             // R11 push across 0x0000
        run_op(1'b1, 0, 3, 2, 11, 1'b0);             // R11 pop across 0xFFFF
        wait_idle();
        chk(rf[2] == 16'h0000, 11, "wrapped pointer", rf[2], 16'h0000);

        wait_idle();
        idle_tag = 10;
        run_op(1'b0, 1, 2, 0, 10, 1'b1);             // R10 start held through done
        wait_idle();
        repeat (4) @(posedge clk);
        #1;
        summary();
    end

endmodule